// File: doc/BRIEF.md
# Multi-Mode I/O Port Controller

This block sits between a small controller core and its pins. It keeps the output latches and the direction state of a group of 4-bit ports and drives the pin output, output-enable and pull-down buses from them. It also selects which port's value comes back on a read.

The ports are of several kinds:
- A bidirectional port that turns itself into an input or an output according to the class of the last instruction that touched it.
- A bidirectional port whose pins each take their direction from a separate direction write.
- Two scan output ports.
- A 2-bit open-drain port whose bits can each pass a PWM signal instead of the latch.
- Two input-only ports. The top bit of the second one can raise an external interrupt request.

The core issues one access per cycle on the `op_*` strobes: a port number, an operation code and a 4-bit data or mask value. Accesses are single-cycle strobes and are always taken, so there is no back-pressure and no valid/ready handshake. Reads and tests are answered combinationally in the same cycle. Writes take effect at the clock edge that samples them.

A standby input puts every driver in high impedance, turns the open-drain transistors off, forces read data to zero and blocks interrupt requests. Latches and direction state are kept while standby is high, so the ports come back as they were when it falls.

Top module: `io_port_ctrl`

## Requirements
- R1: After reset, both bidirectional ports have all output enables at 0. The scan ports drive 0 with their enables at 1. The open-drain pull-downs are off.
- R2: An input-class access to the auto port (port 3) clears all four of its output enables together from the next cycle, and leaves its latch unchanged. The input-class codes are read 0, test-all-ones 1 and test-all-zeros 2. Accesses to other ports leave its direction unchanged.
- R3: An output-class access to the auto port sets all four of its output enables together from the next cycle, and updates its latch. The output-class codes are write 3 (load data), set 4 (OR with mask) and clear 5 (AND with the inverted mask).
- R4: A direction write loads the per-pin port's (port 4) output enables bit by bit, with 1 meaning output. Output-class accesses to that port change its latch but not its directions.
- R5: Output-class accesses to port 1 update scan bits 3:0, and to port 2 update scan bits 7:4, from the next cycle.
- R6: Each open-drain pull-down follows its latch bit (port 6, 1 means pull low) while its PWM select bit is 0. It follows its PWM input while the select bit is 1.
- R7: While standby is high, every output enable and pull-down is 0. When standby falls, latch and direction state come back unchanged.
- R8: The read data returns the selected port's value in the same cycle. This is the pin input for ports 0, 3, 4 and 5, and the latch for ports 1, 2 and 6. It is 0 during standby. The test flag is 1 when, for code 1, all masked bits are 1, or, for code 2, all masked bits are 0.
- R9: A falling edge on the interrupt pin (port 5 bit 3) goes through a two-flop synchronizer. It then raises irq_req for exactly one cycle, two clock edges after the pin falls, but only when irq_en is 1 and standby is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Standby: drivers off, reads zero, no interrupt |
| op_valid | input | 1 | Access strobe for this cycle |
| op_port | input | 3 | Port number of the access |
| op_code | input | 3 | Operation code |
| op_data | input | 4 | Write data or bit mask |
| dir_wr | input | 1 | Direction write strobe for the per-pin port |
| dir_data | input | 4 | Per-pin directions, 1 = output |
| rd_data | output | 4 | Read data of the selected port |
| tst_hit | output | 1 | Result of a test access |
| key_in | input | 4 | Input-only port 0 pins |
| gen_in | input | 4 | Input-only port 5 pins, bit 3 is the interrupt pin |
| irq_en | input | 1 | Interrupt enable |
| irq_req | output | 1 | One-cycle interrupt request |
| e_in | input | 4 | Auto port pin inputs |
| e_out | output | 4 | Auto port latch |
| e_oe | output | 4 | Auto port output enables |
| f_in | input | 4 | Per-pin port pin inputs |
| f_out | output | 4 | Per-pin port latch |
| f_oe | output | 4 | Per-pin port output enables |
| scan_out | output | 8 | Scan port latches, port 1 in bits 3:0 |
| scan_oe | output | 2 | Scan port enables, one per port |
| pwm_sel | input | 2 | Per-bit PWM select for the open-drain port |
| pwm_in | input | 2 | PWM signals |
| od_pull | output | 2 | Open-drain pull-down on, 1 = pin pulled low |

## Verification
The auto port is driven through alternating sequences of output-class and input-class codes. This separates the six codes by class and checks that the latch survives a direction flip. Write, set and clear are applied with overlapping masks so that OR, AND-NOT and a plain load give different values. Test accesses use masks that are fully set, partly set and fully clear on the same pin pattern, which tells the two test polarities apart. The interrupt pin is given a falling edge with the enable on, with the enable off and during standby, and a rising edge. These separate a gated one-cycle pulse from a level or an edge of the wrong direction.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  localparam int PW    = 4;
  localparam int NSCAN = 2;
  localparam int ODW   = 2;

  typedef enum logic [2:0] {
    PID_KEY   = 3'd0,
    PID_SCAN0 = 3'd1,
    PID_SCAN1 = 3'd2,
    PID_AUTO  = 3'd3,
    PID_PIN   = 3'd4,
    PID_GEN   = 3'd5,
    PID_OD    = 3'd6,
    PID_NONE  = 3'd7
  } port_id_e;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_TST1  = 3'd1,
    OP_TST0  = 3'd2,
    OP_WRITE = 3'd3,
    OP_SET   = 3'd4,
    OP_CLR   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } op_e;

  function automatic logic is_in_op(op_e o);
    return (o == OP_READ) || (o == OP_TST1) || (o == OP_TST0);
  endfunction

  function automatic logic is_out_op(op_e o);
    return (o == OP_WRITE) || (o == OP_SET) || (o == OP_CLR);
  endfunction
endpackage

// File: rtl/io_port_latch.sv
module io_port_latch
  import io_port_pkg::*;
#(
  parameter int W = 4,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  op_e          op,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= RST;
    end else if (we) begin
      case (op)
        OP_WRITE: q <= data;
        OP_SET:   q <= q | data;
        OP_CLR:   q <= q & ~data;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/io_port_auto.sv
module io_port_auto
  import io_port_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         standby,
  input  logic         sel,
  input  op_e          op,
  input  logic [W-1:0] data,
  output logic [W-1:0] q,
  output logic [W-1:0] oe
);
  logic drive_q;

  io_port_latch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n), .we(sel && is_out_op(op)),
    .op(op), .data(data), .q(q)
  );

  // One direction flop for the whole port: the bits cannot disagree.
  always_ff @(posedge clk) begin
    if (!rst_n)                    drive_q <= 1'b0;
    else if (sel && is_out_op(op)) drive_q <= 1'b1;
    else if (sel && is_in_op(op))  drive_q <= 1'b0;
  end

  assign oe = {W{drive_q & ~standby}};
endmodule

// File: rtl/io_port_pindir.sv
module io_port_pindir
  import io_port_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         standby,
  input  logic         sel,
  input  op_e          op,
  input  logic [W-1:0] data,
  input  logic         dir_wr,
  input  logic [W-1:0] dir_data,
  output logic [W-1:0] q,
  output logic [W-1:0] oe
);
  logic [W-1:0] dir_q;

  io_port_latch #(.W(W)) u_latch (
    .clk(clk), .rst_n(rst_n), .we(sel && is_out_op(op)),
    .op(op), .data(data), .q(q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_wr) dir_q <= dir_data;
  end

  assign oe = dir_q & {W{~standby}};
endmodule

// File: rtl/io_irq_sync.sv
module io_irq_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic en,
  input  logic pin,
  output logic req
);
  logic meta_q, sync_q, last_q;

  // Idle level is high, so reset to 1 to avoid a false edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      last_q <= 1'b1;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign req = last_q & ~sync_q & en & ~standby;
endmodule

// File: rtl/io_port_ctrl.sv
module io_port_ctrl
  import io_port_pkg::*;
#(
  parameter int W = io_port_pkg::PW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 standby,
  input  logic                 op_valid,
  input  logic [2:0]           op_port,
  input  logic [2:0]           op_code,
  input  logic [W-1:0]         op_data,
  input  logic                 dir_wr,
  input  logic [W-1:0]         dir_data,
  output logic [W-1:0]         rd_data,
  output logic                 tst_hit,
  input  logic [W-1:0]         key_in,
  input  logic [W-1:0]         gen_in,
  input  logic                 irq_en,
  output logic                 irq_req,
  input  logic [W-1:0]         e_in,
  output logic [W-1:0]         e_out,
  output logic [W-1:0]         e_oe,
  input  logic [W-1:0]         f_in,
  output logic [W-1:0]         f_out,
  output logic [W-1:0]         f_oe,
  output logic [NSCAN*W-1:0]   scan_out,
  output logic [NSCAN-1:0]     scan_oe,
  input  logic [ODW-1:0]       pwm_sel,
  input  logic [ODW-1:0]       pwm_in,
  output logic [ODW-1:0]       od_pull
);
  localparam int IRQ_BIT = W - 1;

  port_id_e     pid;
  op_e          opc;
  logic [ODW-1:0] od_q;
  logic [W-1:0] sel_val;

  assign pid = port_id_e'(op_port);
  assign opc = op_e'(op_code);

  io_port_auto #(.W(W)) u_auto (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .sel(op_valid && pid == PID_AUTO), .op(opc), .data(op_data),
    .q(e_out), .oe(e_oe)
  );

  io_port_pindir #(.W(W)) u_pin (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .sel(op_valid && pid == PID_PIN), .op(opc), .data(op_data),
    .dir_wr(dir_wr), .dir_data(dir_data), .q(f_out), .oe(f_oe)
  );

  for (genvar i = 0; i < NSCAN; i++) begin : g_scan
    io_port_latch #(.W(W)) u_scan (
      .clk(clk), .rst_n(rst_n),
      .we(op_valid && op_port == 3'(int'(PID_SCAN0) + i) && is_out_op(opc)),
      .op(opc), .data(op_data), .q(scan_out[i*W +: W])
    );
    assign scan_oe[i] = ~standby;
  end

  io_port_latch #(.W(ODW)) u_od (
    .clk(clk), .rst_n(rst_n),
    .we(op_valid && pid == PID_OD && is_out_op(opc)),
    .op(opc), .data(op_data[ODW-1:0]), .q(od_q)
  );

  for (genvar b = 0; b < ODW; b++) begin : g_od
    assign od_pull[b] = ~standby & (pwm_sel[b] ? pwm_in[b] : od_q[b]);
  end

  io_irq_sync u_irq (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .en(irq_en), .pin(gen_in[IRQ_BIT]), .req(irq_req)
  );

  always_comb begin
    case (pid)
      PID_KEY:   sel_val = key_in;
      PID_SCAN0: sel_val = scan_out[0 +: W];
      PID_SCAN1: sel_val = scan_out[W +: W];
      PID_AUTO:  sel_val = e_in;
      PID_PIN:   sel_val = f_in;
      PID_GEN:   sel_val = gen_in;
      PID_OD:    sel_val = W'(od_q);
      default:   sel_val = '0;
    endcase
  end

  assign rd_data = standby ? '0 : sel_val;

  always_comb begin
    case (opc)
      OP_TST1: tst_hit = op_valid && ((rd_data & op_data) == op_data);
      OP_TST0: tst_hit = op_valid && ((rd_data & op_data) == '0);
      default: tst_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/io_port_ctrl_chk.sv
module io_port_ctrl_chk #(
  parameter int W = 4,
  parameter int NS = 2,
  parameter int OW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          standby,
  input logic          op_valid,
  input logic [2:0]    op_port,
  input logic [2:0]    op_code,
  input logic          dir_wr,
  input logic [W-1:0]  dir_data,
  input logic [W-1:0]  rd_data,
  input logic          irq_req,
  input logic [W-1:0]  e_oe,
  input logic [W-1:0]  f_oe,
  input logic [NS*W-1:0] scan_out,
  input logic [NS-1:0] scan_oe,
  input logic [OW-1:0] od_pull
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !standby) |->
      (e_oe == '0 && f_oe == '0 && scan_out == '0 && od_pull == '0));

  // R2
  auto_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_port == 3'd3 && op_code <= 3'd2) |=> (standby || e_oe == '0));

  // R3
  auto_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_port == 3'd3 && op_code >= 3'd3 && op_code <= 3'd5)
      |=> (standby || e_oe == '1));

  // R3
  auto_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_oe == '0) || (e_oe == '1));

  // R4
  pin_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (standby || f_oe == $past(dir_data)));

  // R7
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (e_oe == '0 && f_oe == '0 && scan_oe == '0 &&
                 od_pull == '0 && rd_data == '0));

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);
endmodule

bind io_port_ctrl io_port_ctrl_chk #(.W(W), .NS(io_port_pkg::NSCAN), .OW(io_port_pkg::ODW)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .op_valid(op_valid),
  .op_port(op_port), .op_code(op_code), .dir_wr(dir_wr), .dir_data(dir_data),
  .rd_data(rd_data), .irq_req(irq_req), .e_oe(e_oe), .f_oe(f_oe),
  .scan_out(scan_out), .scan_oe(scan_oe), .od_pull(od_pull)
);

// File: tb/io_port_ctrl_tb.sv
module io_port_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_port = '0;
  logic [2:0] op_code = '0;
  logic [3:0] op_data = '0;
  logic       dir_wr = 1'b0;
  logic [3:0] dir_data = '0;
  logic [3:0] rd_data;
  logic       tst_hit;
  logic [3:0] key_in = '0;
  logic [3:0] gen_in = 4'b1000;
  logic       irq_en = 1'b0;
  logic       irq_req;
  logic [3:0] e_in = '0;
  logic [3:0] e_out, e_oe;
  logic [3:0] f_in = '0;
  logic [3:0] f_out, f_oe;
  logic [7:0] scan_out;
  logic [1:0] scan_oe;
  logic [1:0] pwm_sel = '0;
  logic [1:0] pwm_in = '0;
  logic [1:0] od_pull;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .op_valid(op_valid),
    .op_port(op_port), .op_code(op_code), .op_data(op_data),
    .dir_wr(dir_wr), .dir_data(dir_data), .rd_data(rd_data), .tst_hit(tst_hit),
    .key_in(key_in), .gen_in(gen_in), .irq_en(irq_en), .irq_req(irq_req),
    .e_in(e_in), .e_out(e_out), .e_oe(e_oe), .f_in(f_in), .f_out(f_out),
    .f_oe(f_oe), .scan_out(scan_out), .scan_oe(scan_oe), .pwm_sel(pwm_sel),
    .pwm_in(pwm_in), .od_pull(od_pull)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Clocked access: drive after a falling edge, result visible one edge later.
  task automatic do_op(logic [2:0] p, logic [2:0] c, logic [3:0] d);
    @(negedge clk);
    op_valid = 1'b1; op_port = p; op_code = c; op_data = d;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_dir(logic [3:0] d);
    @(negedge clk);
    dir_wr = 1'b1; dir_data = d;
    @(negedge clk);
    dir_wr = 1'b0;
  endtask

  // Combinational probe inside one low phase: no clock edge is crossed.
  task automatic probe(logic [2:0] p, logic [2:0] c, logic [3:0] d);
    @(negedge clk);
    op_valid = 1'b1; op_port = p; op_code = c; op_data = d;
    #1;
  endtask

  task automatic probe_end();
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "e_oe", e_oe, 4'h0);
    check("R1", "f_oe", f_oe, 4'h0);
    check("R1", "scan_out", scan_out, 8'h00);
    check("R1", "scan_oe", scan_oe, 2'b11);
    check("R1", "od_pull", od_pull, 2'b00);
  endtask

  task automatic t_auto();
    do_op(3'd3, 3'd3, 4'hA);
    check("R3", "write oe", e_oe, 4'hF);
    check("R3", "write out", e_out, 4'hA);
    do_op(3'd3, 3'd4, 4'h1);
    check("R3", "set out", e_out, 4'hB);
    do_op(3'd3, 3'd5, 4'h8);
    check("R3", "clear out", e_out, 4'h3);
    do_op(3'd3, 3'd0, 4'h0);
    check("R2", "read oe", e_oe, 4'h0);
    check("R2", "read keeps latch", e_out, 4'h3);
    do_op(3'd3, 3'd4, 4'h4);
    check("R3", "set after read oe", e_oe, 4'hF);
    check("R3", "set after read out", e_out, 4'h7);
    do_op(3'd3, 3'd2, 4'h1);
    check("R2", "test0 oe", e_oe, 4'h0);
    do_op(3'd3, 3'd3, 4'h5);
    check("R3", "rewrite oe", e_oe, 4'hF);
    do_op(3'd3, 3'd1, 4'h1);
    check("R2", "test1 oe", e_oe, 4'h0);
    do_op(3'd4, 3'd3, 4'h9);
    check("R2", "other port leaves dir", e_oe, 4'h0);
    check("R2", "other port leaves latch", e_out, 4'h5);
  endtask

  task automatic t_pin();
    do_dir(4'b0101);
    check("R4", "dir load", f_oe, 4'h5);
    do_op(3'd4, 3'd3, 4'hC);
    check("R4", "latch write", f_out, 4'hC);
    check("R4", "dir unchanged by write", f_oe, 4'h5);
    do_op(3'd4, 3'd0, 4'h0);
    check("R4", "dir unchanged by read", f_oe, 4'h5);
    do_dir(4'b1010);
    check("R4", "dir reload", f_oe, 4'hA);
  endtask

  task automatic t_scan();
    do_op(3'd1, 3'd3, 4'h3);
    check("R5", "scan0 write", scan_out, 8'h03);
    do_op(3'd2, 3'd3, 4'h9);
    check("R5", "scan1 write", scan_out, 8'h93);
    do_op(3'd2, 3'd5, 4'h1);
    check("R5", "scan1 clear", scan_out, 8'h83);
    probe(3'd2, 3'd0, 4'h0);
    check("R8", "read scan1 latch", rd_data, 4'h8);
    probe_end();
  endtask

  task automatic t_od();
    do_op(3'd6, 3'd3, 4'h1);
    check("R6", "latch drive", od_pull, 2'b01);
    @(negedge clk);
    pwm_sel = 2'b10; pwm_in = 2'b10;
    #1;
    check("R6", "pwm high", od_pull, 2'b11);
    pwm_in = 2'b00;
    #1;
    check("R6", "pwm low", od_pull, 2'b01);
    probe(3'd6, 3'd0, 4'h0);
    check("R8", "read od latch", rd_data, 4'h1);
    probe_end();
    pwm_sel = 2'b00;
  endtask

  task automatic t_read();
    key_in = 4'h6; gen_in = 4'b1010; e_in = 4'h5; f_in = 4'h9;
    probe(3'd0, 3'd0, 4'h0);
    check("R8", "key read", rd_data, 4'h6);
    probe(3'd5, 3'd0, 4'h0);
    check("R8", "gen read", rd_data, 4'hA);
    probe(3'd5, 3'd1, 4'b1010);
    check("R8", "test1 full mask", tst_hit, 1'b1);
    probe(3'd5, 3'd1, 4'b1011);
    check("R8", "test1 partial", tst_hit, 1'b0);
    probe(3'd5, 3'd2, 4'b0101);
    check("R8", "test0 clear", tst_hit, 1'b1);
    probe(3'd5, 3'd2, 4'b0110);
    check("R8", "test0 partial", tst_hit, 1'b0);
    probe(3'd3, 3'd0, 4'h0);
    check("R8", "auto pins read", rd_data, 4'h5);
    probe(3'd4, 3'd0, 4'h0);
    check("R8", "pin port read", rd_data, 4'h9);
    probe_end();
    gen_in = 4'b1000;
  endtask

  task automatic t_standby();
    do_op(3'd3, 3'd3, 4'h6);
    do_dir(4'hF);
    @(negedge clk);
    standby = 1'b1; pwm_sel = 2'b11; pwm_in = 2'b11;
    #1;
    check("R7", "e_oe", e_oe, 4'h0);
    check("R7", "f_oe", f_oe, 4'h0);
    check("R7", "scan_oe", scan_oe, 2'b00);
    check("R7", "od_pull", od_pull, 2'b00);
    op_valid = 1'b1; op_port = 3'd0; op_code = 3'd0;
    #1;
    check("R8", "standby read zero", rd_data, 4'h0);
    op_valid = 1'b0;
    repeat (3) @(negedge clk);
    standby = 1'b0; pwm_sel = 2'b00; pwm_in = 2'b00;
    #1;
    check("R7", "auto dir back", e_oe, 4'hF);
    check("R7", "auto latch kept", e_out, 4'h6);
    check("R7", "pin dir back", f_oe, 4'hF);
    check("R7", "scan back", scan_oe, 2'b11);
  endtask

  task automatic t_irq();
    int seen;
    irq_en = 1'b1;
    @(negedge clk); gen_in[3] = 1'b0;
    @(negedge clk);
    check("R9", "no req after one edge", irq_req, 1'b0);
    @(negedge clk);
    check("R9", "req after two edges", irq_req, 1'b1);
    @(negedge clk);
    check("R9", "req lasts one cycle", irq_req, 1'b0);
    seen = 0;
    gen_in[3] = 1'b1;
    repeat (4) begin @(negedge clk); if (irq_req) seen++; end
    check("R9", "rising edge no req", seen, 0);
    irq_en = 1'b0; gen_in[3] = 1'b0; seen = 0;
    repeat (4) begin @(negedge clk); if (irq_req) seen++; end
    check("R9", "disabled no req", seen, 0);
    gen_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    irq_en = 1'b1; standby = 1'b1; gen_in[3] = 1'b0; seen = 0;
    repeat (4) begin @(negedge clk); if (irq_req) seen++; end
    check("R9", "standby no req", seen, 0);
    standby = 1'b0; gen_in[3] = 1'b1; irq_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_auto();
    t_pin();
    t_scan();
    t_od();
    t_read();
    t_standby();
    t_irq();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule